// File: doc/BRIEF.md
# Multi-Channel Block Transfer Engine

The engine holds a parameterised set of one-way transfer channels, 4 by default and at most 15. Each channel moves a block of byte or 16-bit word items between one peripheral register address and a buffer in dual-port RAM. A channel is armed through a small register write port. It is then started, one item at a time, either by an interrupt line it selects with an 8-bit code or by a software trigger write. One shared bus port does all the moves. A fixed-priority arbiter decides which pending channel goes next. Each item costs a grant cycle, a read cycle and a write cycle.

The RAM side can step forward after every item or stay on one address. It can also take its address from a pass-through input that the peripheral drives. A channel can stop itself after one block, or reload and keep running. When it keeps running, it can alternate between two RAM start addresses on successive blocks. Completion of a block, and optionally the half-way point of a block, is signalled by a one-cycle pulse per channel.

Top module: `dma_engine`

## Requirements
- R1: After reset all channels are disabled, bus_req_o, bus_we_o, bus_word_o, bus_addr_o and bus_wdata_o are 0, and no interrupt pulse is raised. All bus outputs are 0 whenever bus_req_o is low.
- R2: The arbiter grants only while the bus is idle, and it grants the lowest-numbered channel that is enabled and pending. The grant cycle is followed by one read cycle (bus_req_o=1, bus_we_o=0, source address) and one write cycle (bus_we_o=1, destination address). The arbiter then decides again.
- R3: A channel becomes pending in the cycle after irq_vec_i[code] is high, where code is its select register (cfg_reg_i=1). Code 0 selects bit 0, and codes at or above NUM_SRC select nothing. A write to cfg_reg_i=6 acts as a software trigger. Requests to a disabled channel are ignored. A request while the channel is pending, or in its grant cycle, is merged and adds no item.
- R4: With the word bit clear (CTRL bit 1), bus_word_o is 0 and the written data is the low byte of the read data, zero-extended. With it set, the full 16 bits are moved and bus_word_o is 1.
- R5: With CTRL bit 2 clear, an item reads the peripheral address (cfg_reg_i=4) and writes the RAM address. With it set, the direction is reversed. The RAM address advances by 1 (byte) or 2 (word) after each item when CTRL bit 4 is set, and stays put when it is clear. With CTRL bit 7 set, the RAM address is peri_addr_i sampled in the grant cycle.
- R6: With CTRL bit 3 set, half_irq_o[ch] pulses for one cycle after the write cycle of the item that leaves floor(L/2) items remaining. L is the count register (cfg_reg_i=5) plus 1.
- R7: done_irq_o[ch] pulses for one cycle after the write cycle of the last item of every block.
- R8: With CTRL bit 5 clear, the channel clears its own enable at the end of the block, and later requests move nothing.
- R9: With CTRL bit 5 set, the channel stays enabled at the end of the block. It reloads L items and the RAM start address.
- R10: With CTRL bits 5 and 6 set, each completed block switches the RAM start between register A (cfg_reg_i=2) and register B (cfg_reg_i=3).
- R11: A CTRL write (cfg_reg_i=0, enable in bit 0) loads all control bits. It also reloads the remaining count to L, selects start A and sets the RAM address to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_ch_i | input | CH_W | Channel addressed by the write |
| cfg_reg_i | input | 3 | Register code: 0 ctrl, 1 select, 2 start A, 3 start B, 4 peripheral address, 5 count, 6 trigger |
| cfg_data_i | input | ADDR_W | Write data |
| irq_vec_i | input | NUM_SRC | Interrupt request lines |
| peri_addr_i | input | ADDR_W | Peripheral-generated RAM address |
| bus_req_o | output | 1 | Bus cycle active |
| bus_we_o | output | 1 | Write cycle (0 = read) |
| bus_word_o | output | 1 | Item is a 16-bit word |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | 16 | Write data |
| bus_rdata_i | input | 16 | Read data, valid in the read cycle |
| half_irq_o | output | NUM_CH | Half-block pulse per channel |
| done_irq_o | output | NUM_CH | Block-complete pulse per channel |

## Verification
The hardest case to reach is a request merging into one that is already pending. That needs the channel to stay pending across a cycle, which only happens while a lower-numbered channel holds the bus. The stimulus raises a shared line for two channels and the line of a third channel together. It then repeats the third line in the next cycle, while the first channel is being granted. Ping-pong alternation is reached with single-item blocks in repeat mode, so three triggers cover A, B and A again. A CTRL rewrite after an odd number of blocks shows the reload back to start A.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    REG_CTRL = 3'd0,
    REG_SEL  = 3'd1,
    REG_STA  = 3'd2,
    REG_STB  = 3'd3,
    REG_PAD  = 3'd4,
    REG_CNT  = 3'd5,
    REG_TRIG = 3'd6
  } cfg_reg_e;

  // bit 7 down to bit 0
  typedef struct packed {
    logic paddr;
    logic pingpong;
    logic rpt;
    logic incr;
    logic half_en;
    logic to_periph;
    logic word;
    logic en;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xfer_st_e;
endpackage

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 8,
  parameter int NUM_SRC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_reg_i,
  input  logic [ADDR_W-1:0] cfg_data_i,
  input  logic [NUM_SRC-1:0] irq_vec_i,
  input  logic [ADDR_W-1:0] peri_addr_i,
  input  logic              grant_i,
  input  logic              item_done_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] src_addr_o,
  output logic [ADDR_W-1:0] dst_addr_o,
  output logic              word_o,
  output logic              half_o,
  output logic              done_o
);
  localparam int SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  ctrl_t             ctrl_q;
  logic [7:0]        sel_q;
  logic [ADDR_W-1:0] sta_q, stb_q, pad_q, ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W:0]    rem_q;
  logic              bsel_q, pend_q, half_q, done_q;

  logic [CNT_W:0]    len, rem_nx;
  logic [ADDR_W-1:0] ram_addr, step;
  logic              src_hit, trig, nsel;

  assign len      = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign rem_nx   = rem_q - (CNT_W+1)'(1);
  assign src_hit  = (int'(sel_q) < NUM_SRC) && irq_vec_i[sel_q[SEL_W-1:0]];
  assign trig     = cfg_we_i && (cfg_reg_i == REG_TRIG);
  assign ram_addr = ctrl_q.paddr ? peri_addr_i : ptr_q;
  assign step     = ctrl_q.word ? ADDR_W'(2) : ADDR_W'(1);
  assign nsel     = bsel_q ^ ctrl_q.pingpong;

  assign src_addr_o = ctrl_q.to_periph ? ram_addr : pad_q;
  assign dst_addr_o = ctrl_q.to_periph ? pad_q : ram_addr;
  assign word_o     = ctrl_q.word;
  assign pend_o     = pend_q & ctrl_q.en;
  assign half_o     = half_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      sel_q  <= '0;
      sta_q  <= '0;
      stb_q  <= '0;
      pad_q  <= '0;
      ptr_q  <= '0;
      cnt_q  <= '0;
      rem_q  <= '0;
      bsel_q <= 1'b0;
      pend_q <= 1'b0;
      half_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      half_q <= 1'b0;
      done_q <= 1'b0;
      // merge: a request while pending or being granted adds nothing
      if (!ctrl_q.en)             pend_q <= 1'b0;
      else if (grant_i)           pend_q <= 1'b0;
      else if (src_hit || trig)   pend_q <= 1'b1;

      if (cfg_we_i) begin
        case (cfg_reg_i)
          REG_CTRL: begin
            ctrl_q <= ctrl_t'(cfg_data_i[7:0]);
            rem_q  <= len;
            bsel_q <= 1'b0;
            ptr_q  <= sta_q;
          end
          REG_SEL: sel_q <= cfg_data_i[7:0];
          REG_STA: sta_q <= cfg_data_i;
          REG_STB: stb_q <= cfg_data_i;
          REG_PAD: pad_q <= cfg_data_i;
          REG_CNT: cnt_q <= cfg_data_i[CNT_W-1:0];
          default: ;
        endcase
      end else if (item_done_i) begin
        rem_q <= rem_nx;
        if (ctrl_q.incr) ptr_q <= ptr_q + step;
        if (ctrl_q.half_en && (rem_nx == (len >> 1))) half_q <= 1'b1;
        if (rem_nx == '0) begin
          done_q <= 1'b1;
          if (ctrl_q.rpt) begin
            rem_q  <= len;
            bsel_q <= nsel;
            ptr_q  <= nsel ? stb_q : sta_q;
          end else begin
            ctrl_q.en <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int NUM_CH = 4
) (
  input  logic              en_i,
  input  logic [NUM_CH-1:0] req_i,
  output logic [NUM_CH-1:0] gnt_o
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign gnt_o[i] = en_i & req_i[i];
    end else begin : g_low
      assign gnt_o[i] = en_i & req_i[i] & ~(|req_i[i-1:0]);
    end
  end
endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
  import dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CH_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              gnt_any_i,
  input  logic [CH_W-1:0]   gnt_ch_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic              word_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic              bus_word_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic              idle_o,
  output logic              item_done_o,
  output logic [CH_W-1:0]   cur_ch_o
);
  xfer_st_e          st_q;
  logic [CH_W-1:0]   ch_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic              word_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ch_q   <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      word_q <= 1'b0;
      data_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (gnt_any_i) begin
          st_q   <= ST_RD;
          ch_q   <= gnt_ch_i;
          src_q  <= src_i;
          dst_q  <= dst_i;
          word_q <= word_i;
        end
        ST_RD: begin
          st_q   <= ST_WR;
          data_q <= word_q ? bus_rdata_i : {8'h00, bus_rdata_i[7:0]};
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o      = (st_q == ST_IDLE);
  assign item_done_o = (st_q == ST_WR);
  assign cur_ch_o    = ch_q;
  assign bus_req_o   = (st_q != ST_IDLE);
  assign bus_we_o    = (st_q == ST_WR);
  assign bus_word_o  = bus_req_o & word_q;
  assign bus_addr_o  = (st_q == ST_RD) ? src_q : (st_q == ST_WR) ? dst_q : '0;
  assign bus_wdata_o = (st_q == ST_WR) ? data_q : '0;
endmodule

// File: rtl/dma_engine.sv
module dma_engine
  import dma_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int NUM_SRC = 16,
  parameter int ADDR_W  = 16,
  parameter int CNT_W   = 8,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [CH_W-1:0]    cfg_ch_i,
  input  logic [2:0]         cfg_reg_i,
  input  logic [ADDR_W-1:0]  cfg_data_i,
  input  logic [NUM_SRC-1:0] irq_vec_i,
  input  logic [ADDR_W-1:0]  peri_addr_i,
  output logic               bus_req_o,
  output logic               bus_we_o,
  output logic               bus_word_o,
  output logic [ADDR_W-1:0]  bus_addr_o,
  output logic [15:0]        bus_wdata_o,
  input  logic [15:0]        bus_rdata_i,
  output logic [NUM_CH-1:0]  half_irq_o,
  output logic [NUM_CH-1:0]  done_irq_o
);
  logic [NUM_CH-1:0] chan_pend, chan_gnt, chan_done, chan_word;
  logic [ADDR_W-1:0] chan_src [NUM_CH];
  logic [ADDR_W-1:0] chan_dst [NUM_CH];
  logic [CH_W-1:0]   gnt_idx, cur_ch;
  logic              xfer_idle, item_done;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dma_chan #(
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .NUM_SRC(NUM_SRC)
    ) i_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (cfg_we_i && (cfg_ch_i == CH_W'(i))),
      .cfg_reg_i  (cfg_reg_i),
      .cfg_data_i (cfg_data_i),
      .irq_vec_i  (irq_vec_i),
      .peri_addr_i(peri_addr_i),
      .grant_i    (chan_gnt[i]),
      .item_done_i(chan_done[i]),
      .pend_o     (chan_pend[i]),
      .src_addr_o (chan_src[i]),
      .dst_addr_o (chan_dst[i]),
      .word_o     (chan_word[i]),
      .half_o     (half_irq_o[i]),
      .done_o     (done_irq_o[i])
    );
    assign chan_done[i] = item_done && (cur_ch == CH_W'(i));
  end

  dma_arb #(.NUM_CH(NUM_CH)) i_arb (
    .en_i (xfer_idle),
    .req_i(chan_pend),
    .gnt_o(chan_gnt)
  );

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chan_gnt[i]) gnt_idx = CH_W'(i);
    end
  end

  dma_xfer #(.ADDR_W(ADDR_W), .CH_W(CH_W)) i_xfer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .gnt_any_i  (|chan_gnt),
    .gnt_ch_i   (gnt_idx),
    .src_i      (chan_src[gnt_idx]),
    .dst_i      (chan_dst[gnt_idx]),
    .word_i     (chan_word[gnt_idx]),
    .bus_rdata_i(bus_rdata_i),
    .bus_req_o  (bus_req_o),
    .bus_we_o   (bus_we_o),
    .bus_word_o (bus_word_o),
    .bus_addr_o (bus_addr_o),
    .bus_wdata_o(bus_wdata_o),
    .idle_o     (xfer_idle),
    .item_done_o(item_done),
    .cur_ch_o   (cur_ch)
  );
endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [NUM_CH-1:0] gnt_i,
  input logic [NUM_CH-1:0] pend_i,
  input logic [NUM_CH-1:0] done_i,
  input logic [NUM_CH-1:0] half_i
);
  a_r2_gnt_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i));
  a_r2_gnt_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_i) |-> ((gnt_i & pend_i) == gnt_i));
  a_r2_gnt_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt_i) |-> !bus_req_i);
  a_r2_rd_then_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_i && !bus_we_i) |=> (bus_req_i && bus_we_i));
  a_r2_wr_then_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i |=> !bus_req_i);
  a_r7_done_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_i) |-> $past(bus_we_i));
  a_r7_done_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_i));
  a_r6_half_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|half_i) |-> $past(bus_we_i));
endmodule

bind dma_engine dma_engine_chk #(.NUM_CH(NUM_CH)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bus_req_i(bus_req_o),
  .bus_we_i (bus_we_o),
  .gnt_i    (chan_gnt),
  .pend_i   (chan_pend),
  .done_i   (done_irq_o),
  .half_i   (half_irq_o)
);

// File: tb/test_dma_engine.sv
module test_dma_engine;
  localparam int NCH = 4;
  localparam int NSRC = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_ch = '0;
  logic [2:0]  cfg_reg = '0;
  logic [15:0] cfg_data = '0;
  logic [15:0] irq_vec = '0;
  logic [15:0] peri_addr = '0;
  logic        bus_req, bus_we, bus_word;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  half_irq, done_irq;

  assign bus_rdata = bus_addr ^ 16'hA5C3;

  always #5 clk_i = ~clk_i;

  dma_engine i_dma_engine (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_reg_i(cfg_reg), .cfg_data_i(cfg_data),
    .irq_vec_i(irq_vec), .peri_addr_i(peri_addr),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_word_o(bus_word),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .half_irq_o(half_irq), .done_irq_o(done_irq)
  );

  int n_vec = 0, n_mis = 0, cyc = 0, wr_cnt = 0;
  bit fin = 1'b0;
  int done_cnt[NCH], half_cnt[NCH];
  int wr_q[$];

  // reference model state
  int m_ctrl[NCH], m_sel[NCH], m_sta[NCH], m_stb[NCH], m_pad[NCH];
  int m_cnt[NCH], m_rem[NCH], m_ptr[NCH], m_bsel[NCH], m_pend[NCH];
  int m_st, m_cur, m_src, m_dst, m_word, m_data, e_done, e_half;

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_mis++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_ctrl[i] = 0; m_sel[i] = 0; m_sta[i] = 0; m_stb[i] = 0; m_pad[i] = 0;
      m_cnt[i] = 0; m_rem[i] = 0; m_ptr[i] = 0; m_bsel[i] = 0; m_pend[i] = 0;
    end
    m_st = 0; m_cur = 0; m_src = 0; m_dst = 0; m_word = 0; m_data = 0;
    e_done = 0; e_half = 0;
  endtask

  task automatic model_step();
    int g, dch, nd, nh, ram, rd, len, nr;
    bit req;
    g = -1; nd = 0; nh = 0;
    dch = (m_st == 2) ? m_cur : -1;
    if (m_st == 0)
      for (int i = NCH - 1; i >= 0; i--)
        if (m_pend[i] != 0 && (m_ctrl[i] & 1) != 0) g = i;
    for (int i = 0; i < NCH; i++) begin
      req = (m_sel[i] < NSRC && irq_vec[m_sel[i]] == 1'b1) ||
            (cfg_we && int'(cfg_ch) == i && cfg_reg == 3'd6);
      if ((m_ctrl[i] & 1) == 0) m_pend[i] = 0;
      else if (g == i) m_pend[i] = 0;
      else if (req) m_pend[i] = 1;
    end
    case (m_st)
      0: if (g >= 0) begin
        ram = ((m_ctrl[g] & 128) != 0) ? int'(peri_addr) : m_ptr[g];
        m_word = (m_ctrl[g] >> 1) & 1;
        if ((m_ctrl[g] & 4) != 0) begin m_src = ram; m_dst = m_pad[g]; end
        else begin m_src = m_pad[g]; m_dst = ram; end
        m_cur = g; m_st = 1;
      end
      1: begin
        rd = (m_src ^ 'hA5C3) & 'hFFFF;
        m_data = (m_word != 0) ? rd : (rd & 255);
        m_st = 2;
      end
      default: m_st = 0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (cfg_we && int'(cfg_ch) == i) begin
        case (int'(cfg_reg))
          0: begin m_ctrl[i] = cfg_data & 255; m_rem[i] = m_cnt[i] + 1; m_bsel[i] = 0; m_ptr[i] = m_sta[i]; end
          1: m_sel[i] = cfg_data & 255;
          2: m_sta[i] = cfg_data;
          3: m_stb[i] = cfg_data;
          4: m_pad[i] = cfg_data;
          5: m_cnt[i] = cfg_data & 255;
          default: ;
        endcase
      end else if (dch == i) begin
        len = m_cnt[i] + 1;
        nr = m_rem[i] - 1;
        m_rem[i] = nr;
        if ((m_ctrl[i] & 16) != 0) m_ptr[i] = (m_ptr[i] + (((m_ctrl[i] & 2) != 0) ? 2 : 1)) & 'hFFFF;
        if ((m_ctrl[i] & 8) != 0 && nr == len / 2) nh |= (1 << i);
        if (nr == 0) begin
          nd |= (1 << i);
          if ((m_ctrl[i] & 32) != 0) begin
            m_rem[i] = len;
            if ((m_ctrl[i] & 64) != 0) m_bsel[i] ^= 1;
            m_ptr[i] = (m_bsel[i] != 0) ? m_stb[i] : m_sta[i];
          end else m_ctrl[i] &= ~1;
        end
      end
    end
    e_done = nd; e_half = nh;
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) model_reset();
    else model_step();
  end

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !fin) begin
      chk("R2 bus_req", bus_req, m_st != 0);
      chk("R2 bus_we", bus_we, m_st == 2);
      chk("R5 bus_addr", bus_addr, (m_st == 1) ? m_src : (m_st == 2) ? m_dst : 0);
      chk("R4 bus_wdata", bus_wdata, (m_st == 2) ? m_data : 0);
      chk("R4 bus_word", bus_word, (m_st != 0) ? m_word : 0);
      chk("R7 done_irq", done_irq, e_done);
      chk("R6 half_irq", half_irq, e_half);
      if (bus_we) begin wr_cnt++; wr_q.push_back(int'(bus_addr)); end
      for (int i = 0; i < NCH; i++) begin
        if (done_irq[i]) done_cnt[i]++;
        if (half_irq[i]) half_cnt[i]++;
      end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000 && !fin) begin
      fin = 1'b1;
      n_vec++; n_mis++;
      $display("FAIL R2 watchdog: actual %0d expected below 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
      $finish;
    end
  end

  task automatic wr_cfg(input int ch, input int r, input int d);
    @(negedge clk_i);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_reg = 3'(r); cfg_data = 16'(d);
    @(negedge clk_i);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse(input int mask);
    @(negedge clk_i);
    irq_vec = 16'(mask);
    @(negedge clk_i);
    irq_vec = '0;
  endtask

  initial begin
    int w0, d0;
    for (int i = 0; i < NCH; i++) begin done_cnt[i] = 0; half_cnt[i] = 0; end
    idle(3);
    rst_ni = 1'b1;
    idle(2);
    // R1: reset state
    chk("R1 bus_req after reset", bus_req, 0);
    chk("R1 irq after reset", {done_irq, half_irq}, 0);

    // R3: disabled channels ignore requests
    @(negedge clk_i); irq_vec = 16'hFFFF;
    idle(3); irq_vec = '0;
    idle(4);
    chk("R3 disabled channel writes", wr_cnt, 0);

    // ch0: word, incr, half, one-shot, periph->RAM, L=4, select code 2
    wr_cfg(0, 5, 3);
    wr_cfg(0, 2, 'h100);
    wr_cfg(0, 4, 'h40);
    wr_cfg(0, 1, 2);
    wr_cfg(0, 0, 'h1B);
    wr_q.delete();
    for (int k = 0; k < 4; k++) begin pulse(1 << 2); idle(5); end
    chk("R5 ch0 item count", wr_q.size(), 4);
    if (wr_q.size() == 4) begin
      chk("R5 ch0 addr 0", wr_q[0], 'h100);
      chk("R5 ch0 addr 3", wr_q[3], 'h106);
    end
    chk("R7 ch0 done count", done_cnt[0], 1);
    chk("R6 ch0 half count", half_cnt[0], 1);
    w0 = wr_cnt;
    pulse(1 << 2); idle(6);
    chk("R8 one-shot ignores request", wr_cnt - w0, 0);

    // ch1, ch2 share code 5 (byte, to peripheral); ch3 code 7
    for (int c = 1; c < 4; c++) begin
      wr_cfg(c, 5, (c == 3) ? 3 : 1);
      wr_cfg(c, 2, 'h400 + 'h10 * c);
      wr_cfg(c, 4, 'h80 + c);
      wr_cfg(c, 1, (c == 3) ? 7 : 5);
      wr_cfg(c, 0, 'h15);
    end
    w0 = wr_cnt;
    @(negedge clk_i); irq_vec = 16'((1 << 5) | (1 << 7));
    @(negedge clk_i); irq_vec = 16'(1 << 7);
    @(negedge clk_i); irq_vec = '0;
    idle(12);
    chk("R3 merged request items", wr_cnt - w0, 3);

    // ch1: auto-repeat ping-pong, word, L=1
    wr_cfg(1, 5, 0);
    wr_cfg(1, 2, 'h200);
    wr_cfg(1, 3, 'h300);
    wr_cfg(1, 4, 'h50);
    wr_cfg(1, 0, 'h73);
    wr_q.delete();
    d0 = done_cnt[1];
    for (int k = 0; k < 3; k++) begin wr_cfg(1, 6, 0); idle(5); end
    chk("R9 repeat block count", done_cnt[1] - d0, 3);
    chk("R10 ping-pong writes", wr_q.size(), 3);
    if (wr_q.size() == 3) begin
      chk("R10 block 0 start", wr_q[0], 'h200);
      chk("R10 block 1 start", wr_q[1], 'h300);
      chk("R10 block 2 start", wr_q[2], 'h200);
    end
    wr_cfg(1, 0, 'h73);
    wr_q.delete();
    wr_cfg(1, 6, 0); idle(5);
    chk("R11 reload to start A", (wr_q.size() == 1) ? wr_q[0] : -1, 'h200);

    // ch2: peripheral-supplied RAM address, byte, fixed
    peri_addr = 16'h0777;
    wr_cfg(2, 5, 1);
    wr_cfg(2, 4, 'h60);
    wr_cfg(2, 0, 'h81);
    wr_q.delete();
    d0 = done_cnt[2];
    for (int k = 0; k < 2; k++) begin wr_cfg(2, 6, 0); idle(5); end
    chk("R5 peripheral address writes", wr_q.size(), 2);
    if (wr_q.size() == 2) chk("R5 peripheral address", wr_q[1], 'h777);
    chk("R7 ch2 done count", done_cnt[2] - d0, 1);

    idle(4);
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_mis);
    $finish;
  end
endmodule